// File: doc/BRIEF.md
# Dual-Pack Charge Sequencer

This block arbitrates one charging path between two battery channels, called A and B. At any moment it grants at most one channel the right to fast charge or to top off. It also tracks when each channel has finished its work and moves into maintenance trickle. A channel that is present but not granted is flagged as held, so that its own phase controller keeps it in pending trickle until its turn comes.

The sequence follows a fixed interleave. When both packs are present at the start of a cycle, B is fast charged first and A second. The top-offs come after both fast charges, B before A, and only when top-off is enabled. After that, both channels are maintained.

The order is deliberately lopsided. Inserting B does not interrupt a fast charge that A already holds. It does cut short a top-off that A holds, and in that case B starts fast charging at once. Channel A may be discharging while B holds the grant. A channel whose discharge is not yet complete is passed over for fast charge, but it stays held.

Top module: `dual_pack_sequencer`

## Requirements
- R1: While reset is asserted, and on the first clock after reset, every grant, maintenance and hold output is 0.
- R2: At most one of the four grants (fast A, fast B, top A, top B) is high in any cycle.
- R3: A new-cycle pulse with both packs present and top-off enabled grants, in this order: fast B, fast A, top B, top A. Each step advances on the clock after the granted channel's done pulse. After the last step, both maintenance outputs are high.
- R4: With top-off disabled, a fast-done pulse on the granted channel moves that channel straight to maintenance, and it never receives a top grant.
- R5: A fast grant held by A is kept when B is inserted. B receives the fast grant on the clock after A's fast-done pulse.
- R6: A rising presence on B while A holds the top grant ends A's top-off and puts A in maintenance. B receives the fast grant on that same clock, including when A's top-done pulse arrives in the same cycle.
- R7: A rising presence on A while B holds the top grant leaves B's top grant in place. A is held until B's top-done pulse.
- R8: A channel whose discharge-done input is low is not given the fast grant and is held. Once that input goes high while the other channel holds a grant, the channel stays held until the grant is released to it.
- R9: The hold output of a channel is high when the channel waits for fast charge or top-off without holding a grant. Maintenance is high when the channel has completed its work.
- R10: Removing a channel's pack clears all of that channel's outputs on the next clock. If the removed channel held the grant, the grant passes to the other channel on that same clock when the other channel is waiting.
- R11: Fast-done and top-done pulses on a channel that does not hold the matching grant change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| new_cycle | input | 1 | One-clock pulse that restarts the charge cycle on every present pack |
| pres_a | input | 1 | Pack A present |
| pres_b | input | 1 | Pack B present |
| dis_done_a | input | 1 | Channel A discharge complete or not required (ready for fast charge) |
| dis_done_b | input | 1 | Channel B discharge complete or not required |
| fc_done_a | input | 1 | Pulse: channel A fast charge terminated |
| fc_done_b | input | 1 | Pulse: channel B fast charge terminated |
| to_done_a | input | 1 | Pulse: channel A top-off finished |
| to_done_b | input | 1 | Pulse: channel B top-off finished |
| topoff_en | input | 1 | Top-off phase enabled |
| grant_fast_a | output | 1 | Channel A may fast charge |
| grant_fast_b | output | 1 | Channel B may fast charge |
| grant_top_a | output | 1 | Channel A may top off |
| grant_top_b | output | 1 | Channel B may top off |
| maint_a | output | 1 | Channel A in maintenance trickle |
| maint_b | output | 1 | Channel B in maintenance trickle |
| hold_a | output | 1 | Channel A waiting without a grant (pending trickle) |
| hold_b | output | 1 | Channel B waiting without a grant |

## Verification
The interesting collision is an insertion of pack B in the same cycle as a done pulse from channel A. Both events try to release A's grant, and both try to move A's phase.

The bench drives B's presence edge and A's top-done pulse on one clock edge. It then expects exactly one fast grant, on B, with A in maintenance. This is judged on the following clock, and the one-grant property is checked on every cycle.

A second overlap, the removal of the granted pack while the other channel waits, is checked for a hand-over within that single clock.

// File: rtl/dual_pack_sequencer.sv
module dual_pack_sequencer (
  input  logic clk,
  input  logic rst_n,
  input  logic new_cycle,
  input  logic pres_a,
  input  logic pres_b,
  input  logic dis_done_a,
  input  logic dis_done_b,
  input  logic fc_done_a,
  input  logic fc_done_b,
  input  logic to_done_a,
  input  logic to_done_b,
  input  logic topoff_en,
  output logic grant_fast_a,
  output logic grant_fast_b,
  output logic grant_top_a,
  output logic grant_top_b,
  output logic maint_a,
  output logic maint_b,
  output logic hold_a,
  output logic hold_b
);

  typedef enum logic [1:0] {PH_IDLE, PH_FAST, PH_TOP, PH_MAINT} phase_t;

  phase_t     ph_a, ph_b, ph_a_n, ph_b_n;
  logic       pres_a_q, pres_b_q;
  logic [3:0] gnt, gnt_n, pick;
  logic       keep;

  wire ins_a = pres_a & ~pres_a_q;
  wire ins_b = pres_b & ~pres_b_q;

  always_comb begin
    ph_a_n = ph_a;
    ph_b_n = ph_b;
    if (gnt[0] && fc_done_a) ph_a_n = topoff_en ? PH_TOP : PH_MAINT;
    if (gnt[1] && fc_done_b) ph_b_n = topoff_en ? PH_TOP : PH_MAINT;
    if (gnt[2] && to_done_a) ph_a_n = PH_MAINT;
    if (gnt[3] && to_done_b) ph_b_n = PH_MAINT;
    if (gnt[2] && ins_b)     ph_a_n = PH_MAINT;
    if (new_cycle) begin
      ph_a_n = PH_FAST;
      ph_b_n = PH_FAST;
    end
    if (ins_a)   ph_a_n = PH_FAST;
    if (ins_b)   ph_b_n = PH_FAST;
    if (!pres_a) ph_a_n = PH_IDLE;
    if (!pres_b) ph_b_n = PH_IDLE;
  end

  assign keep = !new_cycle &&
                ((gnt[0] && ph_a_n == PH_FAST) || (gnt[1] && ph_b_n == PH_FAST) ||
                 (gnt[2] && ph_a_n == PH_TOP)  || (gnt[3] && ph_b_n == PH_TOP));

  always_comb begin
    if (ph_b_n == PH_FAST && dis_done_b)      pick = 4'b0010;
    else if (ph_a_n == PH_FAST && dis_done_a) pick = 4'b0001;
    else if (ph_b_n == PH_TOP)                pick = 4'b1000;
    else if (ph_a_n == PH_TOP)                pick = 4'b0100;
    else                                      pick = 4'b0000;
  end

  assign gnt_n = keep ? gnt : pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_a     <= PH_IDLE;
      ph_b     <= PH_IDLE;
      pres_a_q <= 1'b0;
      pres_b_q <= 1'b0;
      gnt      <= 4'b0000;
    end else begin
      ph_a     <= ph_a_n;
      ph_b     <= ph_b_n;
      pres_a_q <= pres_a;
      pres_b_q <= pres_b;
      gnt      <= gnt_n;
    end
  end

  assign grant_fast_a = gnt[0];
  assign grant_fast_b = gnt[1];
  assign grant_top_a  = gnt[2];
  assign grant_top_b  = gnt[3];
  assign maint_a      = ph_a == PH_MAINT;
  assign maint_b      = ph_b == PH_MAINT;
  assign hold_a       = (ph_a == PH_FAST || ph_a == PH_TOP) && !gnt[0] && !gnt[2];
  assign hold_b       = (ph_b == PH_FAST || ph_b == PH_TOP) && !gnt[1] && !gnt[3];

endmodule

// File: rtl/dual_pack_sequencer_chk.sv
module dual_pack_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic new_cycle,
  input logic pres_a,
  input logic pres_b,
  input logic fc_done_a,
  input logic topoff_en,
  input logic grant_fast_a,
  input logic grant_fast_b,
  input logic grant_top_a,
  input logic grant_top_b,
  input logic maint_a,
  input logic hold_a
);

  a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_top_b, grant_top_a, grant_fast_b, grant_fast_a}));

  a_r10_absent_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pres_a |=> (!grant_fast_a && !grant_top_a && !hold_a && !maint_a));

  a_r5_fast_not_preempted: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_fast_a && pres_a && !fc_done_a && !new_cycle) |=> grant_fast_a);

  a_r6_insert_b_ends_top_a: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_top_a && $rose(pres_b)) |=> (!grant_top_a && grant_fast_b));

  a_r4_skip_top: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_fast_a && fc_done_a && !topoff_en && pres_a && !new_cycle)
      |=> (!grant_top_a && maint_a));

endmodule

bind dual_pack_sequencer dual_pack_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .new_cycle(new_cycle), .pres_a(pres_a), .pres_b(pres_b),
  .fc_done_a(fc_done_a), .topoff_en(topoff_en),
  .grant_fast_a(grant_fast_a), .grant_fast_b(grant_fast_b),
  .grant_top_a(grant_top_a), .grant_top_b(grant_top_b),
  .maint_a(maint_a), .hold_a(hold_a)
);

// File: tb/dual_pack_sequencer_tb.sv
`timescale 1ns/1ps
module dual_pack_sequencer_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic new_cycle, pres_a, pres_b, dis_done_a, dis_done_b;
  logic fc_done_a, fc_done_b, to_done_a, to_done_b, topoff_en;
  logic grant_fast_a, grant_fast_b, grant_top_a, grant_top_b;
  logic maint_a, maint_b, hold_a, hold_b;
  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  dual_pack_sequencer u_dut (.*);

  // fields: [21:18] requirement, [17:8] inputs {new,pa,pb,ra,rb,fca,fcb,toa,tob,ten},
  // [7:0] expected {gfa,gfb,gta,gtb,ma,mb,ha,hb}
  localparam int N = 33;
  localparam logic [21:0] VEC [N] = '{
    {4'd3,  10'b1_11_11_0000_1, 8'b01000010},  // R3 start both: fast B, A held
    {4'd3,  10'b0_11_11_0000_1, 8'b01000010},
    {4'd3,  10'b0_11_11_0100_1, 8'b10000001},  // R3 B done -> fast A
    {4'd3,  10'b0_11_11_0000_1, 8'b10000001},
    {4'd3,  10'b0_11_11_1000_1, 8'b00010010},  // R3 A done -> top B
    {4'd3,  10'b0_11_11_0001_1, 8'b00100100},  // R3 top A
    {4'd3,  10'b0_11_11_0010_1, 8'b00001100},  // R3 both maintained
    {4'd9,  10'b0_11_11_0000_1, 8'b00001100},  // R9
    {4'd4,  10'b1_11_11_0000_0, 8'b01000010},  // R4 top-off disabled
    {4'd4,  10'b0_11_11_0100_0, 8'b10000100},
    {4'd4,  10'b0_11_11_1000_0, 8'b00001100},
    {4'd11, 10'b0_11_11_1111_0, 8'b00001100},  // R11 stray done pulses
    {4'd10, 10'b0_10_11_0000_1, 8'b00001000},  // R10 B removed
    {4'd5,  10'b1_10_11_0000_1, 8'b10000000},  // R5 only A
    {4'd5,  10'b0_11_11_0000_1, 8'b10000001},  // R5 B inserted, A keeps
    {4'd5,  10'b0_11_11_1000_1, 8'b01000010},  // R5 B after A done
    {4'd3,  10'b0_11_11_0100_1, 8'b00010010},
    {4'd3,  10'b0_11_11_0001_1, 8'b00100100},
    {4'd6,  10'b0_10_11_0000_1, 8'b00100000},  // R6 A top alone
    {4'd6,  10'b0_11_11_0000_1, 8'b01001000},  // R6 insert B preempts
    {4'd10, 10'b0_10_11_0000_1, 8'b00001000},  // R10 active removed
    {4'd10, 10'b1_11_11_0000_1, 8'b01000010},
    {4'd10, 10'b0_10_11_0000_1, 8'b10000000},  // R10 hand-over
    {4'd7,  10'b0_10_11_1000_1, 8'b00100000},
    {4'd10, 10'b0_00_11_0000_1, 8'b00000000},
    {4'd7,  10'b0_01_11_0000_1, 8'b01000000},
    {4'd7,  10'b0_01_11_0100_1, 8'b00010000},
    {4'd7,  10'b0_11_11_0000_1, 8'b00010010},  // R7 insert A keeps B top
    {4'd7,  10'b0_11_11_0001_1, 8'b10000100},
    {4'd8,  10'b1_11_01_0000_1, 8'b01000010},  // R8 A discharging
    {4'd8,  10'b0_11_01_0100_1, 8'b00010010},
    {4'd8,  10'b0_11_11_0000_1, 8'b00010010},  // R8 ready but still held
    {4'd8,  10'b0_11_11_0001_1, 8'b10000100}
  };

  task automatic apply(input logic [9:0] v);
    {new_cycle, pres_a, pres_b, dis_done_a, dis_done_b,
     fc_done_a, fc_done_b, to_done_a, to_done_b, topoff_en} = v;
  endtask

  task automatic check(input int req, input logic [7:0] exp);
    logic [7:0] act;
    act = {grant_fast_a, grant_fast_b, grant_top_a, grant_top_b,
           maint_a, maint_b, hold_a, hold_b};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d outputs act=%b exp=%b", req, act, exp);
    end
    checks++;
    if ($countones(act[7:4]) > 1) begin  // R2
      failures++;
      $display("FAIL R2 grants act=%b exp=onehot0", act[7:4]);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp<20000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    apply(10'b0);
    repeat (3) @(negedge clk);
    check(1, 8'b0);          // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 8'b0);          // R1 after release
    for (int i = 0; i < N; i++) begin
      apply(VEC[i][17:8]);
      @(negedge clk);
      check(int'(VEC[i][21:18]), VEC[i][7:0]);
    end
    // R1 reset in mid-sequence
    rst_n = 1'b0;
    apply(10'b0);
    @(negedge clk);
    check(1, 8'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 insertion of B and A top-done in the same cycle
    apply(10'b1_10_11_0000_1);
    @(negedge clk);
    check(6, 8'b10000000);
    apply(10'b0_10_11_1000_1);
    @(negedge clk);
    check(6, 8'b00100000);
    apply(10'b0_11_11_0010_1);
    @(negedge clk);
    check(6, 8'b01001000);
    apply(10'b0_11_11_0000_1);
    @(negedge clk);
    check(6, 8'b01001000);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule